// File: doc/BRIEF.md
# Set-Associative Data-Side Translation Buffer with Per-Set Tree Replacement

This block holds a small set-associative table of address translations for the data side of a processor. Each cycle it picks a set, either from the MMU-side address when that request is valid or from the load/store-side address, and registers that set's valid bits, tags and page-table entries. The next cycle it compares the registered tags against the registered request tag. The result is a hit flag, the binary number of the hit way, and the hit way's page-table entry.

Each set has its own binary-tree pseudo-LRU tracker. That tracker moves only when a registered hit falls in its set, and it names the way a new translation replaces. A load strobe writes one translation into the victim way of the indexed set. An invalidate strobe clears every valid bit. Page-table walking, permission checks and the data cache lie outside the block.

Top module: `dtlb_set_assoc`

## Requirements
- R1: The set index and request tag come from `mmu_addr` when `mmu_valid` is 1 and from `ls_addr` when it is 0, in the same cycle.
- R2: The set index is address bits [PAGE_SHIFT +: log2(SETS)]. The request tag is every address bit above the index field (bits 31:14 with default parameters).
- R3: At the clock edge where a request is presented, the indexed set's valid bits, tags and PTEs appear on `way_valid_q`, `way_tag_q` and `way_pte_q`. Way w occupies bit w, `way_tag_q[w*TAG_W +: TAG_W]` and `way_pte_q[w*PTE_W +: PTE_W]`.
- R4: While `stall` is 1, the registered way outputs and the registered request tag keep their values.
- R5: `hit` is 1 when a registered way is valid and its tag equals the registered request tag. `hit_way` is that way's binary number and `hit_pte` is its PTE. At most one way matches.
- R6: A set's tracker updates only at the edge after a registered hit whose registered set index equals that set. The trackers of other sets do not change.
- R7: The tracker is a tree of WAYS-1 node bits, all 0 after reset, so the victim is way 0. Each node value selects a child: 0 for the lower-numbered subtree, 1 for the higher. An access sets every node on its path to point away from the accessed way. `victim_way` gives the tracker's choice for the currently selected set.
- R8: When `load_en` is 1, the selected tag, `load_pte` and a set valid bit are written into way `victim_way` of the selected set at the clock edge.
- R9: When `inval_all` is 1, every valid bit is cleared at the clock edge, and a `load_en` in the same cycle is ignored.
- R10: Synchronous reset clears all valid bits, all tracker state and the registered way outputs, so `hit` is 0 and `victim_way` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mmu_valid | input | 1 | MMU-side request valid; selects the index source |
| mmu_addr | input | ADDR_W | MMU-side address |
| ls_addr | input | ADDR_W | Load/store-side address |
| stall | input | 1 | Hold the registered way outputs |
| load_en | input | 1 | Write a translation into the victim way |
| load_pte | input | PTE_W | PTE to be written |
| inval_all | input | 1 | Clear every valid bit |
| way_valid_q | output | WAYS | Registered valid bits of the indexed set |
| way_tag_q | output | WAYS*TAG_W | Registered tags of the indexed set |
| way_pte_q | output | WAYS*PTE_W | Registered PTEs of the indexed set |
| hit | output | 1 | A registered way matches the registered tag |
| hit_way | output | log2(WAYS) | Binary number of the matching way |
| hit_pte | output | PTE_W | PTE of the matching way |
| victim_way | output | log2(WAYS) | Replacement choice for the selected set |

## Verification
Tracker state is visible only through `victim_way`, and only for the set currently selected. It changes two edges after the lookup that caused it. Showing that one set's hit leaves the other sets alone therefore needs the stimulus to fill one set way by way, with a held lookup between loads that lets each hit reach the tracker, and then to steer the index to an untouched set and read its victim. The filling order is also where a wrong tree update shows. A reference model follows every edge, including stalled cycles and random mixes of both address sources, so a late or misrouted update shows up as a wrong victim and a wrong later load placement.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
   // width of a way number; a single-way table still gets one bit
   function automatic int wbits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/dtlb_plru_tree.sv
module dtlb_plru_tree import dtlb_pkg::*; #(
   parameter int WAYS = 4,
   localparam int WB = wbits(WAYS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          acc_en,
   input  logic [WB-1:0] acc_way,
   output logic [WB-1:0] victim
);
   localparam int LG    = $clog2(WAYS);
   localparam int NODES = WAYS - 1;

   if (WAYS < 2 || !is_pow2(WAYS)) begin : g_bad
      $error("tree tracker needs a power-of-two way count of at least 2");
   end

   logic [NODES-1:0] node, node_nxt;

   // point every node on the accessed path away from the accessed way
   always_comb begin
      int n;
      node_nxt = node;
      n = 0;
      for (int l = 0; l < LG; l++) begin
         node_nxt[n] = ~acc_way[LG-1-l];
         n = 2 * n + 1 + int'(acc_way[LG-1-l]);
      end
   end

   always_ff @(posedge clk) begin
      if (rst)         node <= '0;
      else if (acc_en) node <= node_nxt;
   end

   // walk from the root following node bits
   always_comb begin
      int n;
      victim = '0;
      n = 0;
      for (int l = 0; l < LG; l++) begin
         victim[LG-1-l] = node[n];
         n = 2 * n + 1 + int'(node[n]);
      end
   end

   // R7: right after an access the tracker never names the way just used
   assert_victim_moves_R7: assert property (@(posedge clk) disable iff (rst)
      acc_en |=> (victim != $past(acc_way)));
endmodule

// File: rtl/dtlb_way_store.sv
module dtlb_way_store import dtlb_pkg::*; #(
   parameter int SETS  = 4,
   parameter int WAYS  = 4,
   parameter int TAG_W = 18,
   parameter int PTE_W = 16,
   localparam int SB = $clog2(SETS),
   localparam int WB = wbits(WAYS)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               stall,
   input  logic [SB-1:0]      rd_idx,
   input  logic [TAG_W-1:0]   req_tag,
   input  logic               inval,
   input  logic               wr_en,
   input  logic [WB-1:0]      wr_way,
   input  logic [PTE_W-1:0]   wr_pte,
   output logic [WAYS-1:0]    q_valid,
   output logic [WAYS*TAG_W-1:0] q_tag,
   output logic [WAYS*PTE_W-1:0] q_pte,
   output logic [SB-1:0]      q_idx,
   output logic [TAG_W-1:0]   q_req_tag
);
   logic [WAYS-1:0]  vld     [SETS];
   logic [TAG_W-1:0] tag_mem [SETS][WAYS];
   logic [PTE_W-1:0] pte_mem [SETS][WAYS];

   // R9 gives invalidate priority over a load in the same cycle
   always_ff @(posedge clk) begin
      if (rst || inval) begin
         for (int s = 0; s < SETS; s++) vld[s] <= '0;
      end else if (wr_en) begin
         vld[rd_idx][wr_way] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst && !inval && wr_en) begin
         tag_mem[rd_idx][wr_way] <= req_tag;
         pte_mem[rd_idx][wr_way] <= wr_pte;
      end
   end

   // one register stage from index to way outputs, held while stalled
   always_ff @(posedge clk) begin
      if (rst) begin
         q_valid   <= '0;
         q_tag     <= '0;
         q_pte     <= '0;
         q_idx     <= '0;
         q_req_tag <= '0;
      end else if (!stall) begin
         q_valid   <= vld[rd_idx];
         q_idx     <= rd_idx;
         q_req_tag <= req_tag;
         for (int w = 0; w < WAYS; w++) begin
            q_tag[w*TAG_W +: TAG_W] <= tag_mem[rd_idx][w];
            q_pte[w*PTE_W +: PTE_W] <= pte_mem[rd_idx][w];
         end
      end
   end

   // checker state for the load property
   logic [SETS*WAYS-1:0] vld_flat;
   logic [SB-1:0]        chk_idx;
   logic [WB-1:0]        chk_way;
   logic [TAG_W-1:0]     chk_tag;
   always_comb for (int s = 0; s < SETS; s++) vld_flat[s*WAYS +: WAYS] = vld[s];
   always_ff @(posedge clk) begin
      chk_idx <= rd_idx;
      chk_way <= wr_way;
      chk_tag <= req_tag;
   end

   assert_hold_on_stall_R4: assert property (@(posedge clk) disable iff (rst)
      stall |=> ($stable(q_valid) && $stable(q_tag) && $stable(q_pte) && $stable(q_req_tag)));

   assert_inval_clears_R9: assert property (@(posedge clk) disable iff (rst)
      inval |=> (vld_flat == '0));

   assert_load_lands_R8: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !inval) |=> (vld[chk_idx][chk_way] && (tag_mem[chk_idx][chk_way] == chk_tag)));
endmodule

// File: rtl/dtlb_hit_match.sv
module dtlb_hit_match import dtlb_pkg::*; #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 18,
   parameter int PTE_W = 16,
   localparam int WB = wbits(WAYS)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [WAYS-1:0]       q_valid,
   input  logic [WAYS*TAG_W-1:0] q_tag,
   input  logic [WAYS*PTE_W-1:0] q_pte,
   input  logic [TAG_W-1:0]      req_tag,
   output logic                  hit,
   output logic [WB-1:0]         hit_way,
   output logic [PTE_W-1:0]      hit_pte
);
   logic [WAYS-1:0] match;

   always_comb begin
      hit_way = '0;
      hit_pte = '0;
      for (int w = 0; w < WAYS; w++) begin
         match[w] = q_valid[w] && (q_tag[w*TAG_W +: TAG_W] == req_tag);
         if (match[w]) begin
            hit_way = hit_way | WB'(w);
            hit_pte = hit_pte | q_pte[w*PTE_W +: PTE_W];
         end
      end
      hit = |match;
   end

   assert_single_match_R5: assert property (@(posedge clk) disable iff (rst)
      $onehot0(match));

   assert_hit_is_valid_R5: assert property (@(posedge clk) disable iff (rst)
      hit |-> q_valid[hit_way]);
endmodule

// File: rtl/dtlb_set_assoc.sv
module dtlb_set_assoc import dtlb_pkg::*; #(
   parameter int ADDR_W     = 32,
   parameter int PAGE_SHIFT = 12,
   parameter int SETS       = 4,
   parameter int WAYS       = 4,
   parameter int PTE_W      = 16,
   localparam int SB    = $clog2(SETS),
   localparam int TAG_W = ADDR_W - PAGE_SHIFT - SB,
   localparam int WB    = wbits(WAYS)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  mmu_valid,
   input  logic [ADDR_W-1:0]     mmu_addr,
   input  logic [ADDR_W-1:0]     ls_addr,
   input  logic                  stall,
   input  logic                  load_en,
   input  logic [PTE_W-1:0]      load_pte,
   input  logic                  inval_all,
   output logic [WAYS-1:0]       way_valid_q,
   output logic [WAYS*TAG_W-1:0] way_tag_q,
   output logic [WAYS*PTE_W-1:0] way_pte_q,
   output logic                  hit,
   output logic [WB-1:0]         hit_way,
   output logic [PTE_W-1:0]      hit_pte,
   output logic [WB-1:0]         victim_way
);
   if (SETS < 2 || !is_pow2(SETS)) begin : g_bad_sets
      $error("set count must be a power of two of at least 2");
   end
   if (!is_pow2(WAYS)) begin : g_bad_ways
      $error("way count must be a power of two");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address leaves no tag bits above the index");
   end

   // index and tag are formed in the request cycle, no register in between
   logic [SB-1:0]    req_idx;
   logic [TAG_W-1:0] req_tag;
   assign req_idx = mmu_valid ? mmu_addr[PAGE_SHIFT +: SB] : ls_addr[PAGE_SHIFT +: SB];
   assign req_tag = mmu_valid ? mmu_addr[ADDR_W-1 -: TAG_W] : ls_addr[ADDR_W-1 -: TAG_W];

   logic [SB-1:0]    q_idx;
   logic [TAG_W-1:0] q_req_tag;

   dtlb_way_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PTE_W(PTE_W)) u_store (
      .clk       (clk),
      .rst       (rst),
      .stall     (stall),
      .rd_idx    (req_idx),
      .req_tag   (req_tag),
      .inval     (inval_all),
      .wr_en     (load_en),
      .wr_way    (victim_way),
      .wr_pte    (load_pte),
      .q_valid   (way_valid_q),
      .q_tag     (way_tag_q),
      .q_pte     (way_pte_q),
      .q_idx     (q_idx),
      .q_req_tag (q_req_tag)
   );

   dtlb_hit_match #(.WAYS(WAYS), .TAG_W(TAG_W), .PTE_W(PTE_W)) u_match (
      .clk     (clk),
      .rst     (rst),
      .q_valid (way_valid_q),
      .q_tag   (way_tag_q),
      .q_pte   (way_pte_q),
      .req_tag (q_req_tag),
      .hit     (hit),
      .hit_way (hit_way),
      .hit_pte (hit_pte)
   );

   // registered hit feeds the trackers one edge later
   logic          hit_q;
   logic [WB-1:0] hit_way_q;
   logic [SB-1:0] hit_idx_q;
   always_ff @(posedge clk) begin
      if (rst) begin
         hit_q     <= 1'b0;
         hit_way_q <= '0;
         hit_idx_q <= '0;
      end else begin
         hit_q     <= hit;
         hit_way_q <= hit_way;
         hit_idx_q <= q_idx;
      end
   end

   if (WAYS > 1) begin : g_plru
      logic [WB-1:0] vic [SETS];
      for (genvar s = 0; s < SETS; s++) begin : g_set
         logic upd;
         assign upd = hit_q && (hit_idx_q == SB'(s));
         dtlb_plru_tree #(.WAYS(WAYS)) u_tree (
            .clk    (clk),
            .rst    (rst),
            .acc_en (upd),
            .acc_way(hit_way_q),
            .victim (vic[s])
         );
      end
      assign victim_way = vic[req_idx];
   end else begin : g_one_way
      assign victim_way = '0;
   end
endmodule

// File: tb/dtlb_set_assoc_test.sv
`timescale 1ns/1ps
module dtlb_set_assoc_test;
   localparam int TW = 18;
   localparam int PW = 16;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst = 1'b1, mmu_valid = 1'b0, stall = 1'b0, load_en = 1'b0, inval_all = 1'b0;
   logic [31:0]   mmu_addr = '0, ls_addr = '0;
   logic [PW-1:0] load_pte = '0;
   logic [3:0]    way_valid_q;
   logic [4*TW-1:0] way_tag_q;
   logic [4*PW-1:0] way_pte_q;
   logic          hit;
   logic [1:0]    hit_way, victim_way;
   logic [PW-1:0] hit_pte;

   dtlb_set_assoc uut (
      .clk(clk), .rst(rst), .mmu_valid(mmu_valid), .mmu_addr(mmu_addr), .ls_addr(ls_addr),
      .stall(stall), .load_en(load_en), .load_pte(load_pte), .inval_all(inval_all),
      .way_valid_q(way_valid_q), .way_tag_q(way_tag_q), .way_pte_q(way_pte_q),
      .hit(hit), .hit_way(hit_way), .hit_pte(hit_pte), .victim_way(victim_way));

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;
   string cur = "R10";

   // reference model state
   bit mv [4][4];
   int mt [4][4];
   int mp [4][4];
   bit rv [4];
   int rt [4];
   int rp [4];
   int r_idx = 0, r_tag = 0;
   bit hq = 0;
   int hwq = 0, hiq = 0;
   int tr [4][3];

   function automatic int idx_of(input logic [31:0] a); return int'(a[13:12]); endfunction
   function automatic int tag_of(input logic [31:0] a); return int'(a[31:14]); endfunction
   function automatic logic [31:0] mk(input int tag, input int set, input int off);
      return {tag[17:0], set[1:0], off[11:0]};
   endfunction

   function automatic int victim_of(input int s);
      int n = 0, v = 0;
      for (int l = 0; l < 2; l++) begin
         v = v * 2 + tr[s][n];
         n = 2 * n + 1 + tr[s][n];
      end
      return v;
   endfunction

   task automatic touch(input int s, input int w);
      int n = 0;
      for (int l = 0; l < 2; l++) begin
         int b = (w >> (1 - l)) & 1;
         tr[s][n] = 1 - b;
         n = 2 * n + 1 + b;
      end
   endtask

   task automatic model_hit(output bit h, output int hw, output int hp);
      h = 0; hw = 0; hp = 0;
      for (int w = 0; w < 4; w++)
         if (rv[w] && rt[w] == r_tag) begin h = 1; hw = w; hp = rp[w]; end
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
      end
   endtask

   function automatic logic [31:0] sel_addr();
      return mmu_valid ? mmu_addr : ls_addr;
   endfunction

   task automatic model_edge();
      int idx = idx_of(sel_addr());
      int tg  = tag_of(sel_addr());
      int vic = victim_of(idx);
      bit h; int hw, hp;
      model_hit(h, hw, hp);
      if (rst) begin
         for (int s = 0; s < 4; s++) begin
            for (int w = 0; w < 4; w++) mv[s][w] = 0;
            for (int k = 0; k < 3; k++) tr[s][k] = 0;
         end
         for (int w = 0; w < 4; w++) begin rv[w] = 0; rt[w] = 0; rp[w] = 0; end
         r_idx = 0; r_tag = 0; hq = 0; hwq = 0; hiq = 0;
      end else begin
         if (hq) touch(hiq, hwq);
         hq = h; hwq = hw; hiq = r_idx;
         if (!stall) begin
            for (int w = 0; w < 4; w++) begin rv[w] = mv[idx][w]; rt[w] = mt[idx][w]; rp[w] = mp[idx][w]; end
            r_idx = idx; r_tag = tg;
         end
         if (inval_all) begin
            for (int s = 0; s < 4; s++) for (int w = 0; w < 4; w++) mv[s][w] = 0;
         end else if (load_en) begin
            mv[idx][vic] = 1; mt[idx][vic] = tg; mp[idx][vic] = int'(load_pte);
         end
      end
   endtask

   task automatic compare_all();
      bit h; int hw, hp;
      model_hit(h, hw, hp);
      for (int w = 0; w < 4; w++) begin
         chk({cur, " valid"}, int'(way_valid_q[w]), int'(rv[w]));
         chk({cur, " tag"}, int'(way_tag_q[w*TW +: TW]), rt[w]);
      end
      chk({cur, " hit"}, int'(hit), int'(h));
      if (h) begin
         chk({cur, " hit_way"}, int'(hit_way), hw);
         chk({cur, " hit_pte"}, int'(hit_pte), hp);
      end
      chk({cur, " victim"}, int'(victim_way), victim_of(idx_of(sel_addr())));
   endtask

   // inputs are set after a falling edge; one rising edge; compare at the next falling edge
   task automatic step();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare_all();
   endtask

   task automatic lookup_ls(input int tag, input int set, input int cycles);
      mmu_valid = 0; load_en = 0; inval_all = 0; stall = 0;
      ls_addr = mk(tag, set, 12'h3a4);
      for (int i = 0; i < cycles; i++) step();
   endtask

   task automatic load_ls(input int tag, input int set, input int pte);
      mmu_valid = 0; stall = 0; inval_all = 0;
      ls_addr = mk(tag, set, 12'h010); load_en = 1; load_pte = pte[PW-1:0];
      step();
      load_en = 0;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog (R1..R10 unfinished): actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] lf;
      @(negedge clk);
      // R10: reset state
      cur = "R10";
      rst = 1; step(); step();
      rst = 0;
      chk("R10 reset valid", int'(way_valid_q), 0);
      chk("R10 reset hit", int'(hit), 0);
      chk("R10 reset victim", int'(victim_way), 0);

      // R8 and R7: fill set 1 way by way, each entry hit so its tracker moves
      cur = "R8";
      for (int k = 0; k < 4; k++) begin
         load_ls(10 + k, 1, 16'h1000 + k);
         cur = "R7";
         lookup_ls(10 + k, 1, 3);
         if (k == 0) chk("R7 victim after hit on way 0", int'(victim_way), 2);
         cur = "R8";
      end
      lookup_ls(0, 1, 1);
      chk("R8 set 1 full", int'(way_valid_q), 4'hf);
      chk("R2 tag field way 0", int'(way_tag_q[0 +: TW]), 10);
      chk("R3 pte field way 3", int'(way_pte_q[3*PW +: PW]), 16'h1003);

      // R6: other sets' trackers untouched
      cur = "R6";
      lookup_ls(0, 0, 1);
      chk("R6 set 0 victim", int'(victim_way), 0);

      // R1: MMU address wins when valid
      cur = "R1";
      mmu_valid = 1; mmu_addr = mk(12, 1, 12'hfff); ls_addr = mk(99, 3, 0);
      step();
      chk("R1 mmu hit", int'(hit), 1);
      chk("R1 mmu hit way", int'(hit_way), 1);
      chk("R5 hit pte", int'(hit_pte), 16'h1002);
      mmu_valid = 0; step();
      chk("R1 ls side miss", int'(hit), 0);

      // R4: stall holds the registered ways
      cur = "R4";
      lookup_ls(13, 1, 1);
      stall = 1; ls_addr = mk(7, 0, 0);
      step(); step(); step();
      chk("R4 held hit", int'(hit), 1);
      chk("R4 held way", int'(hit_way), 3);
      stall = 0;

      // R9: invalidate wins over load
      cur = "R9";
      ls_addr = mk(20, 2, 0); load_en = 1; inval_all = 1; load_pte = 16'h5555;
      step();
      load_en = 0; inval_all = 0;
      lookup_ls(20, 2, 2);
      chk("R9 no valid after invalidate", int'(way_valid_q), 0);
      chk("R9 load ignored", int'(hit), 0);
      lookup_ls(11, 1, 2);
      chk("R9 set 1 cleared", int'(way_valid_q), 0);

      // R5, R3: random mix of both address sources, stalls and loads
      cur = "R5";
      lf = 16'hace1;
      for (int i = 0; i < 800; i++) begin
         int tg, st;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         tg = int'(lf[2:0]) % 6;
         st = int'(lf[4:3]);
         mmu_valid = lf[5];
         if (lf[5]) begin mmu_addr = mk(tg, st, int'(lf[15:8])); ls_addr = mk(tg + 1, st ^ 1, 0); end
         else begin ls_addr = mk(tg, st, int'(lf[15:8])); mmu_addr = mk(5, 3, 0); end
         stall = (lf[7:6] == 2'b11);
         inval_all = (lf[15:9] == 7'h55);
         load_en = 0;
         if (lf[8]) begin
            bit present = 0;
            for (int w = 0; w < 4; w++) if (mv[st][w] && mt[st][w] == tg) present = 1;
            load_en = !present;
         end
         load_pte = {lf[7:0], lf[15:8]};
         step();
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule